// File: doc/BRIEF.md
# Five-Bit Successive-Approximation Converter Sequencer

This block steps a two-channel, 5-bit analog-to-digital conversion by successive approximation. A start strobe latches the channel select and begins the sequence. For each step the block drives a trial code to an external resistor-ladder DAC. It then samples an external comparator at the end of a fixed-length trial window. When the last bit is decided, the block latches the code into a result register and raises a completion flag. That flag drops when the result is read or when a new conversion begins.

The analog full scale is tied to a fixed fraction of the 3 V rail, not to a reference pin. Code 31 stands for 63/96 of that rail. With the default trial length of 32000 clocks at 125 MHz, each trial lasts 256 µs and a conversion takes 1.28 ms.

The block also carries the per-pin selection between digital input and analog input for the two shared pins. A pin set to analog reads back as logic low on its digital path. In the low-power hold state every shared pin reads low. The comparator, the ladder and the analog multiplexer lie outside the block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, result_o and dac_code_o are all zero, and both pins are in digital mode (pin_read_o follows pin_raw_i).
- R2: The clock after an accepted start, dac_code_o holds only the most significant bit set (5'b10000).
- R3: Bits are decided from most to least significant. A trial bit is kept when cmp_i is high (input at or above the DAC level) and cleared otherwise, so the result is the largest code whose level does not exceed the input, saturating at 31.
- R4: Each bit trial lasts STEP_CYCLES clocks. done_o rises exactly BITS*STEP_CYCLES clocks after the edge that accepts the start.
- R5: A start strobe while busy_o is high is ignored. The conversion continues on its original channel with its original timing.
- R6: done_o rises when a conversion finishes. It clears on the clock after rd_i or after an accepted start, and is never high while busy_o is high.
- R7: mux_sel_o takes the value of chan_i on the accepting edge and holds it for the whole conversion.
- R8: pin_mode_we_i loads pin_mode_i, one bit per pin, with 1 meaning analog and 0 meaning digital. A pin in analog mode reads 0 on pin_read_o, and a pin in digital mode reads its pin_raw_i.
- R9: While hold_i is high, every bit of pin_read_o is 0.
- R10: result_o changes only at the completion of a conversion and holds its value through reads and idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start strobe |
| chan_i | input | CH_W | Channel to convert |
| rd_i | input | 1 | Result read strobe, clears done_o |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC level |
| dac_code_o | output | BITS | Trial code to the resistor DAC |
| mux_sel_o | output | CH_W | Analog multiplexer select |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Completion flag |
| result_o | output | BITS | Last converted code |
| hold_i | input | 1 | Low-power hold; disables digital inputs |
| pin_mode_we_i | input | 1 | Load strobe for pin modes |
| pin_mode_i | input | CHANNELS | Per-pin mode: 1 analog, 0 digital |
| pin_raw_i | input | CHANNELS | Pad levels of the shared pins |
| pin_read_o | output | CHANNELS | Digital read of the shared pins |

## Verification
The bench sweeps the input level across every quarter-LSB from zero to past full scale on both channels. This catches an off-by-one threshold, which would round instead of truncate, and a lost saturation, which would show up at the top. Each conversion is timed to the exact clock, so a timer that miscounts its window makes done_o early or late. A start strobe issued mid-conversion with a different channel shows whether a design restarts or switches its multiplexer. Read-clear, start-clear, per-pin analog masking and hold masking are each checked, because a design that got any of them wrong would leave the flag stuck or leak pad levels onto the digital path.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_CONV = 1'b1} sar_state_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
  parameter int unsigned STEP_CYCLES = 32000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic step_end_o
);
  localparam int unsigned CNT_W = sar_adc_pkg::clog2_min1(STEP_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign step_end_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clear_i)    cnt_q <= '0;
    else if (step_end_o) cnt_q <= '0;
    else if (run_i)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int unsigned BITS = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic            step_end_i,
  input  logic            cmp_i,
  output logic            busy_o,
  output logic [BITS-1:0] trial_o,
  output logic            finish_o,
  output logic [BITS-1:0] final_code_o
);
  import sar_adc_pkg::*;
  localparam logic [BITS-1:0] MSB = {1'b1, {(BITS-1){1'b0}}};

  sar_state_e      state_q;
  logic [BITS-1:0] probe_q;   // one-hot bit under trial
  logic [BITS-1:0] decided;

  assign busy_o       = (state_q == ST_CONV);
  assign decided      = cmp_i ? trial_o : (trial_o & ~probe_q);
  assign finish_o     = busy_o && step_end_i && probe_q[0];
  assign final_code_o = decided;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      probe_q <= '0;
      trial_o <= '0;
    end else if (accept_i) begin
      state_q <= ST_CONV;
      probe_q <= MSB;
      trial_o <= MSB;
    end else if (busy_o && step_end_i) begin
      probe_q <= probe_q >> 1;
      trial_o <= decided | (probe_q >> 1);
      if (probe_q[0]) state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/sar_pin_cfg.sv
module sar_pin_cfg #(
  parameter int unsigned CHANNELS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [CHANNELS-1:0] mode_i,
  input  logic                hold_i,
  input  logic [CHANNELS-1:0] raw_i,
  output logic [CHANNELS-1:0] read_o
);
  for (genvar g = 0; g < CHANNELS; g++) begin : g_pin
    logic analog_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   analog_q <= 1'b0;
      else if (we_i) analog_q <= mode_i[g];
    end
    assign read_o[g] = raw_i[g] & ~analog_q & ~hold_i;
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int unsigned BITS        = 5,
  parameter int unsigned CHANNELS    = 2,
  parameter int unsigned STEP_CYCLES = 32000,
  localparam int unsigned CH_W       = sar_adc_pkg::clog2_min1(CHANNELS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic                rd_i,
  input  logic                cmp_i,
  output logic [BITS-1:0]     dac_code_o,
  output logic [CH_W-1:0]     mux_sel_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [BITS-1:0]     result_o,
  input  logic                hold_i,
  input  logic                pin_mode_we_i,
  input  logic [CHANNELS-1:0] pin_mode_i,
  input  logic [CHANNELS-1:0] pin_raw_i,
  output logic [CHANNELS-1:0] pin_read_o
);
  logic            accept, step_end, finish;
  logic [BITS-1:0] final_code;

  assign accept = start_i && !busy_o;

  sar_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept), .run_i(busy_o),
    .step_end_o(step_end)
  );

  sar_sequencer #(.BITS(BITS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .step_end_i(step_end),
    .cmp_i(cmp_i), .busy_o(busy_o), .trial_o(dac_code_o), .finish_o(finish),
    .final_code_o(final_code)
  );

  sar_pin_cfg #(.CHANNELS(CHANNELS)) u_pins (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(pin_mode_we_i), .mode_i(pin_mode_i),
    .hold_i(hold_i), .raw_i(pin_raw_i), .read_o(pin_read_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mux_sel_o <= '0;
      done_o    <= 1'b0;
      result_o  <= '0;
    end else begin
      if (accept) mux_sel_o <= chan_i;
      if (finish) result_o  <= final_code;
      if (accept)      done_o <= 1'b0;
      else if (finish) done_o <= 1'b1;   // completion wins over a coincident read
      else if (rd_i)   done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int unsigned BITS     = 5,
  parameter int unsigned CHANNELS = 2,
  parameter int unsigned CH_W     = 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [BITS-1:0]     dac_code_o,
  input logic [CH_W-1:0]     mux_sel_o,
  input logic                busy_o,
  input logic                done_o,
  input logic [BITS-1:0]     result_o,
  input logic                hold_i,
  input logic [CHANNELS-1:0] pin_raw_i,
  input logic [CHANNELS-1:0] pin_read_o
);
  localparam logic [BITS-1:0] MSB = {1'b1, {(BITS-1){1'b0}}};

  a_r2_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (dac_code_o == MSB));

  a_r6_start_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  a_r6_done_excl_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  a_r7_chan_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mux_sel_o));

  a_r8_no_spurious_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_read_o & ~pin_raw_i) == '0));

  a_r9_hold_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> (pin_read_o == '0));

  a_r10_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_o) |-> $stable(result_o));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.BITS(BITS), .CHANNELS(CHANNELS), .CH_W(CH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dac_code_o(dac_code_o),
  .mux_sel_o(mux_sel_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
  .hold_i(hold_i), .pin_raw_i(pin_raw_i), .pin_read_o(pin_read_o)
);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
  localparam int BITS = 5, CHANNELS = 2, STEP = 4, CH_W = 1;
  localparam int MAXC = (1 << BITS) - 1;

  logic clk = 0, rst_n = 0;
  logic start = 0, rd = 0, hold = 0, mwe = 0, cmp;
  logic [CH_W-1:0] chan = '0, mux;
  logic [CHANNELS-1:0] mode = '0, raw = '0, pread;
  logic [BITS-1:0] dac, res;
  logic busy, done;
  int vin4 [CHANNELS];
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  assign cmp = (vin4[mux] >= int'(dac) * 4);

  sar_adc_ctrl #(.BITS(BITS), .CHANNELS(CHANNELS), .STEP_CYCLES(STEP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan), .rd_i(rd),
    .cmp_i(cmp), .dac_code_o(dac), .mux_sel_o(mux), .busy_o(busy), .done_o(done),
    .result_o(res), .hold_i(hold), .pin_mode_we_i(mwe), .pin_mode_i(mode),
    .pin_raw_i(raw), .pin_read_o(pread)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_code(input int v4);
    return (v4 / 4 > MAXC) ? MAXC : v4 / 4;
  endfunction

  // start at next edge; optional mid-conversion restart attempt on other channel
  task automatic convert(input int ch, input bit poke);
    @(negedge clk); start = 1; chan = CH_W'(ch);
    @(posedge clk); #1;
    check("R2 msb trial", int'(dac), 1 << (BITS-1));
    check("R6 start clears done", int'(done), 0);
    @(negedge clk); start = 0;
    for (int c = 1; c < BITS*STEP; c++) begin
      if (poke && c == 7) begin start = 1; chan = CH_W'(ch ^ 1); end
      @(posedge clk); #1;
      if (poke && c == 7) begin
        check("R5 ignored start keeps chan", int'(mux), ch);
        @(negedge clk); start = 0;
      end
      if (done) begin
        check("R4 early done", c, BITS*STEP);
        return;
      end
    end
    @(posedge clk); #1;
    check("R4 done at window end", int'(done), 1);
    check("R7 chan latched", int'(mux), ch);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    vin4[0] = 0; vin4[1] = 0;
    raw = 2'b11;
    #20; @(negedge clk); rst_n = 1;
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 result", int'(res), 0);
    check("R1 dac", int'(dac), 0);
    check("R1 pins digital", int'(pread), 3);

    // R3: sweep every quarter LSB on alternating channels
    for (int v = 0; v <= 4*MAXC + 11; v++) begin
      int ch = v % 2;
      vin4[ch] = v; vin4[ch^1] = 4*MAXC + 11 - v;
      convert(ch, 0);
      check("R3 code", int'(res), expect_code(v));
    end

    // R5: restart attempt mid-conversion
    vin4[0] = 37; vin4[1] = 101;
    convert(0, 1);
    check("R5 result from first channel", int'(res), expect_code(37));

    // R6/R10: read clears done, result held
    @(negedge clk); rd = 1;
    @(posedge clk); #1;
    check("R6 read clears done", int'(done), 0);
    @(negedge clk); rd = 0;
    repeat (5) @(posedge clk); #1;
    check("R10 result held", int'(res), expect_code(37));
    check("R6 stays clear", int'(done), 0);

    // R8: per-pin analog masking
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 4; r++) begin
        @(negedge clk); mode = 2'(m); mwe = 1; raw = 2'(r);
        @(negedge clk); mwe = 0;
        check("R8 pin read", int'(pread), r & ~m & 3);
      end
    end
    // R9: hold masks all pins
    @(negedge clk); mode = 2'b00; mwe = 1; raw = 2'b11;
    @(negedge clk); mwe = 0; hold = 1;
    #1 check("R9 hold read", int'(pread), 0);
    @(negedge clk); hold = 0;
    #1 check("R9 release read", int'(pread), 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule